// File: doc/BRIEF.md
# Serial Channel FIFO Pair with Threshold Interrupts

This block holds the receive and transmit byte queues of one serial channel and decides when each side should ask the host for service. The serializer side writes received bytes into the receive queue and takes bytes to send from the transmit queue. The host side reads the receive queue and loads the transmit queue. A single size control sets both queues to a shallow depth of 8 or a deep depth of 256. Each queue has its own 2-bit threshold code. The receive request compares bytes held against a level. The transmit request compares free slots against a level. The levels are not linear in the code, and they change with the depth.

A receive watchdog covers the tail of a message that is too short to reach the receive level. When it is enabled, it counts receiver bit-time ticks while unread data sits in the receive queue and no access occurs. After 64 ticks it latches a receive request, which holds until the host reads a byte. Both requests are level outputs. They are recomputed every cycle from the current fill counts and control inputs.

Top module: `uart_fifo_irq_ctrl`

## Requirements
- R1: After reset both fill counts are 0 and `rx_irq` is 0. With `tx_code` = 00, `tx_irq` equals `tx_en`.
- R2: Each queue returns bytes in write order. The head byte is visible on its read-data port while the queue is not empty. An accepted push adds 1 to the count and an accepted pop removes 1. A push to a full queue is dropped, even when a pop occurs in the same cycle. A pop from an empty queue is ignored.
- R3: When `size_sel` = 0 each queue holds at most 8 bytes. When `size_sel` = 1 each queue holds at most 256 bytes.
- R4: At depth 8, `rx_irq` is raised by the receive level when the count is at least 1, 3, 6 or 8, for receive codes 00, 01, 10 and 11 respectively.
- R5: At depth 256, `rx_irq` is raised by the receive level when the count is at least 1, 128, 192 or 256, for codes 00, 01, 10 and 11.
- R6: At depth 8, with `tx_en` = 1, `tx_irq` is raised when the number of free transmit slots (depth minus count) is exactly 8, at least 4, at least 6, or at least 1, for `tx_code` 00, 01, 10 and 11.
- R7: At depth 256, with `tx_en` = 1, `tx_irq` is raised when the free transmit slots number exactly 256, at least 128, at least 192, or at least 1, for `tx_code` 00, 01, 10 and 11.
- R8: `tx_irq` is 0 whenever `tx_en` = 0. With code 00 it drops in the cycle after the first byte is loaded into an empty transmit queue.
- R9: The receive code is {`rx_code_hi`, `rx_code_lo`}, with `rx_code_hi` as bit 1.
- R10: With `wdog_en` = 1, the watchdog latches a receive request on the 64th `bit_tick` counted while the receive queue is non-empty and has had no accepted push or pop. The request stays on, including across pushes, until an accepted receive pop clears it. `rx_irq` is the OR of this request and the receive level.
- R11: The following events restart the watchdog count at zero: an accepted receive push or pop, the receive queue being empty, or `wdog_en` = 0. While `wdog_en` = 0 the latched request is also held clear.
- R12: When `size_sel` differs from its value in the previous cycle, both queues are emptied and the watchdog request is cleared at the next edge, and pushes and pops in that cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| size_sel | input | 1 | Queue depth: 0 selects 8 entries, 1 selects 256 entries |
| tx_en | input | 1 | Transmitter enable; gates the transmit request |
| rx_code_hi | input | 1 | Bit 1 of the receive threshold code |
| rx_code_lo | input | 1 | Bit 0 of the receive threshold code |
| tx_code | input | 2 | Transmit threshold code |
| wdog_en | input | 1 | Receive watchdog enable |
| bit_tick | input | 1 | One pulse per receiver 1x bit time |
| rx_push | input | 1 | Serializer writes a received byte |
| rx_wdata | input | 8 | Received byte |
| rx_pop | input | 1 | Host reads the receive head |
| rx_rdata | output | 8 | Receive head byte |
| rx_count | output | 9 | Bytes held in the receive queue |
| tx_push | input | 1 | Host loads a byte to send |
| tx_wdata | input | 8 | Byte to send |
| tx_pop | input | 1 | Serializer takes the transmit head |
| tx_rdata | output | 8 | Transmit head byte |
| tx_count | output | 9 | Bytes held in the transmit queue |
| rx_irq | output | 1 | Receive interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
The hardest case to reach is the exact cycle in which the watchdog fires. Reaching it needs a non-empty receive queue, a steady stream of ticks and a quiet window of 64 of them, and then the latch must be shown to survive pushes and to clear only on a read. The stimulus sets the receive code to its full-queue level so that the level term stays low and the watchdog alone drives `rx_irq`. It then restarts the count with a mid-window push, uses gapped ticks, toggles the enable and ends with a size change. Meanwhile a behavioural model tracks the count tick by tick and compares the request on every clock. The deep-queue levels need full 256-byte fill and drain runs for each code, on both queues at once.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  typedef logic [15:0] lvl_t;

  // Bytes that must be held to request a receive interrupt
  function automatic lvl_t rx_need(input logic [1:0] code, input lvl_t cap,
                                   input logic deep, input lvl_t sh_mid,
                                   input lvl_t sh_upr);
    case (code)
      2'b00:   return lvl_t'(1);
      2'b01:   return deep ? (cap >> 1) : sh_mid;
      2'b10:   return deep ? (cap - (cap >> 2)) : sh_upr;
      default: return cap;
    endcase
  endfunction

  // Free slots that must exist to request a transmit interrupt
  function automatic lvl_t tx_need(input logic [1:0] code, input lvl_t cap);
    case (code)
      2'b00:   return cap;
      2'b01:   return cap >> 1;
      2'b10:   return cap - (cap >> 2);
      default: return lvl_t'(1);
    endcase
  endfunction
endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
  parameter int DW        = 8,
  parameter int DEPTH_MAX = 256,
  parameter int CW        = $clog2(DEPTH_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [CW-1:0] cap,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count,
  output logic          push_ok,
  output logic          pop_ok
);
  localparam int AW = $clog2(DEPTH_MAX);

  logic [DW-1:0] mem [DEPTH_MAX];
  logic [AW-1:0] wr_ptr, rd_ptr, last_slot;

  assign last_slot = AW'(cap - CW'(1));
  assign push_ok   = push & ~flush & (count < cap);
  assign pop_ok    = pop  & ~flush & (count != '0);
  assign rdata     = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == last_slot) ? '0 : wr_ptr + AW'(1);
      if (pop_ok)  rd_ptr <= (rd_ptr == last_slot) ? '0 : rd_ptr + AW'(1);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= cap); // R3
  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok && !pop_ok |=> count == $past(count) + CW'(1)); // R2
  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok && !push_ok |=> count == $past(count) - CW'(1)); // R2
endmodule

// File: rtl/uart_rx_watchdog.sv
module uart_rx_watchdog #(
  parameter int TIMEOUT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic flush,
  input  logic tick,
  input  logic nonempty,
  input  logic access,
  input  logic pop_ok,
  output logic flag
);
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [TW-1:0] LAST = TW'(TIMEOUT - 1);
  localparam logic [TW-1:0] SAT  = TW'(TIMEOUT);

  logic [TW-1:0] cnt;
  logic          restart, expire;

  assign restart = ~en | flush | access | ~nonempty;
  assign expire  = ~restart & tick & (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else begin
      if (restart)                  cnt <= '0;
      else if (tick && cnt != SAT)  cnt <= cnt + TW'(1);
      if (!en || flush || pop_ok)   flag <= 1'b0;
      else if (expire)              flag <= 1'b1;
    end
  end

  AST_WDOG_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(nonempty && en && tick)); // R10
  AST_WDOG_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !pop_ok && !flush && en |=> flag); // R10
  AST_WDOG_OFF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !flag); // R11
endmodule

// File: rtl/uart_fifo_irq_ctrl.sv
module uart_fifo_irq_ctrl #(
  parameter int DW        = 8,
  parameter int DEEP      = 256,
  parameter int SHALLOW   = 8,
  parameter int SH_RX_MID = 3,
  parameter int SH_RX_UPR = 6,
  parameter int WDOG_BITS = 64,
  parameter int CW        = $clog2(DEEP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          size_sel,
  input  logic          tx_en,
  input  logic          rx_code_hi,
  input  logic          rx_code_lo,
  input  logic [1:0]    tx_code,
  input  logic          wdog_en,
  input  logic          bit_tick,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_wdata,
  input  logic          rx_pop,
  output logic [DW-1:0] rx_rdata,
  output logic [CW-1:0] rx_count,
  input  logic          tx_push,
  input  logic [DW-1:0] tx_wdata,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_rdata,
  output logic [CW-1:0] tx_count,
  output logic          rx_irq,
  output logic          tx_irq
);
  import uart_fifo_pkg::*;

  logic          size_q, flush;
  logic [CW-1:0] cap, tx_free;
  logic [1:0]    rx_code;
  logic          rx_push_ok, rx_pop_ok, tx_push_ok, tx_pop_ok;
  logic          rx_level_hit, tx_level_hit, wdog_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) size_q <= 1'b0;
    else        size_q <= size_sel;
  end

  assign flush   = size_sel ^ size_q;
  assign cap     = size_q ? CW'(DEEP) : CW'(SHALLOW);
  assign rx_code = {rx_code_hi, rx_code_lo};
  assign tx_free = cap - tx_count;

  uart_byte_fifo #(.DW(DW), .DEPTH_MAX(DEEP), .CW(CW)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush), .cap(cap),
    .push(rx_push), .wdata(rx_wdata), .pop(rx_pop), .rdata(rx_rdata),
    .count(rx_count), .push_ok(rx_push_ok), .pop_ok(rx_pop_ok));

  uart_byte_fifo #(.DW(DW), .DEPTH_MAX(DEEP), .CW(CW)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush), .cap(cap),
    .push(tx_push), .wdata(tx_wdata), .pop(tx_pop), .rdata(tx_rdata),
    .count(tx_count), .push_ok(tx_push_ok), .pop_ok(tx_pop_ok));

  uart_rx_watchdog #(.TIMEOUT(WDOG_BITS)) u_rx_wdog (
    .clk(clk), .rst_n(rst_n), .en(wdog_en), .flush(flush), .tick(bit_tick),
    .nonempty(rx_count != '0), .access(rx_push_ok | rx_pop_ok),
    .pop_ok(rx_pop_ok), .flag(wdog_flag));

  assign rx_level_hit = lvl_t'(rx_count) >=
    rx_need(rx_code, lvl_t'(cap), size_q, lvl_t'(SH_RX_MID), lvl_t'(SH_RX_UPR));
  assign tx_level_hit = lvl_t'(tx_free) >= tx_need(tx_code, lvl_t'(cap));

  assign rx_irq = rx_level_hit | wdog_flag;
  assign tx_irq = tx_en & tx_level_hit;

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> rx_count == '0 && tx_count == '0 && !wdog_flag); // R12
  AST_FULL_RX_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count == cap |-> rx_irq); // R4
  AST_TX_LOADED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_code == 2'b00 && tx_count != '0 |-> !tx_irq); // R8
  AST_TX_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !tx_irq); // R8
endmodule

// File: tb/uart_fifo_irq_ctrl_bench.sv
module uart_fifo_irq_ctrl_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, size_sel, tx_en, rx_code_hi, rx_code_lo, wdog_en, bit_tick;
  logic [1:0] tx_code;
  logic rx_push, rx_pop, tx_push, tx_pop;
  logic [7:0] rx_wdata, tx_wdata, rx_rdata, tx_rdata;
  logic [8:0] rx_count, tx_count;
  logic rx_irq, tx_irq;

  uart_fifo_irq_ctrl u_uart_fifo_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .size_sel(size_sel), .tx_en(tx_en),
    .rx_code_hi(rx_code_hi), .rx_code_lo(rx_code_lo), .tx_code(tx_code),
    .wdog_en(wdog_en), .bit_tick(bit_tick),
    .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop),
    .rx_rdata(rx_rdata), .rx_count(rx_count),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop),
    .tx_rdata(tx_rdata), .tx_count(tx_count),
    .rx_irq(rx_irq), .tx_irq(tx_irq));

  logic [7:0] rxq[$];
  logic [7:0] txq[$];
  int   wcnt;
  bit   wflag, msize, done;
  int   checks = 0, errors = 0;
  string cur_req = "R1";
  logic [7:0] seed = 8'h21;

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
    end
  endtask

  function automatic int rx_thr(input int code, input bit deep);
    int lv[4];
    if (deep) lv = '{1, 128, 192, 256};
    else      lv = '{1, 3, 6, 8};
    return lv[code];
  endfunction

  function automatic int tx_thr(input int code, input bit deep);
    int lv[4];
    if (deep) lv = '{256, 128, 192, 1};
    else      lv = '{8, 4, 6, 1};
    return lv[code];
  endfunction

  task automatic model_edge();
    int capm, rx_pre;
    bit rpush, rpop, tpush, tpop;
    capm = msize ? 256 : 8;
    if (size_sel != msize) begin
      rxq.delete(); txq.delete();
      wcnt = 0; wflag = 0; msize = size_sel;
      return;
    end
    rx_pre = rxq.size();
    rpush = rx_push && rx_pre < capm;
    rpop  = rx_pop && rx_pre > 0;
    tpush = tx_push && txq.size() < capm;
    tpop  = tx_pop && txq.size() > 0;
    if (rpop)  void'(rxq.pop_front());
    if (rpush) rxq.push_back(rx_wdata);
    if (tpop)  void'(txq.pop_front());
    if (tpush) txq.push_back(tx_wdata);
    if (!wdog_en) begin
      wcnt = 0; wflag = 0;
    end else begin
      if (rpop) wflag = 0;
      if (rpush || rpop || rx_pre == 0) wcnt = 0;
      else if (bit_tick) begin
        if (wcnt == 63) wflag = 1;
        if (wcnt < 64) wcnt++;
      end
    end
  endtask

  task automatic compare_all();
    int capm, rc;
    capm = msize ? 256 : 8;
    rc = {rx_code_hi, rx_code_lo};
    chk("rx_count", rx_count, rxq.size());
    chk("tx_count", tx_count, txq.size());
    chk("rx_irq", rx_irq, int'(wflag || rxq.size() >= rx_thr(rc, msize)));
    chk("tx_irq", tx_irq, int'(tx_en && (capm - txq.size()) >= tx_thr(tx_code, msize)));
    if (rxq.size() > 0) chk("rx_rdata", rx_rdata, rxq[0]);
    if (txq.size() > 0) chk("tx_rdata", tx_rdata, txq[0]);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
    rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic rxw(input int n);
    for (int i = 0; i < n; i++) begin
      seed = seed * 8'd5 + 8'd3;
      rx_push = 1; rx_wdata = seed; step();
    end
  endtask

  task automatic rxr(input int n);
    for (int i = 0; i < n; i++) begin rx_pop = 1; step(); end
  endtask

  task automatic both_fill(input int n);
    for (int i = 0; i < n; i++) begin
      seed = seed * 8'd5 + 8'd3;
      rx_push = 1; rx_wdata = seed; tx_push = 1; tx_wdata = ~seed; step();
    end
  endtask

  task automatic both_drain(input int n);
    for (int i = 0; i < n; i++) begin rx_pop = 1; tx_pop = 1; step(); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog timer expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    done = 0;
    rst_n = 0; size_sel = 0; tx_en = 1; rx_code_hi = 0; rx_code_lo = 0;
    tx_code = 2'b00; wdog_en = 0; bit_tick = 0;
    rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0;
    rx_wdata = 0; tx_wdata = 0;
    wcnt = 0; wflag = 0; msize = 0;
    repeat (3) @(negedge clk);
    // R1: reset values
    cur_req = "R1";
    compare_all();
    rst_n = 1;
    idle(2);

    // R2: order, overflow, underflow, simultaneous push and pop
    cur_req = "R2";
    rxw(3); rxr(3);
    rxr(2);
    cur_req = "R2 R3";
    rxw(10);
    rx_push = 1; rx_wdata = 8'hA5; rx_pop = 1; step();
    rxr(2);
    rx_push = 1; rx_wdata = 8'h3C; rx_pop = 1; step();
    rxr(10);

    // R4, R9: receive levels at depth 8
    cur_req = "R4 R9";
    for (int c = 0; c < 4; c++) begin
      rx_code_hi = c[1]; rx_code_lo = c[0];
      rxw(9); rxr(9);
    end

    // R6: transmit levels at depth 8
    cur_req = "R6";
    for (int c = 0; c < 4; c++) begin
      tx_code = c[1:0];
      for (int i = 0; i < 9; i++) begin tx_push = 1; tx_wdata = 8'(i + 40); step(); end
      for (int i = 0; i < 9; i++) begin tx_pop = 1; step(); end
    end

    // R12: size change flushes both queues
    cur_req = "R12";
    rx_code_hi = 0; rx_code_lo = 0; tx_code = 2'b00;
    both_fill(5);
    size_sel = 1; rx_push = 1; tx_push = 1; step();
    chk("rx_count after flush", rx_count, 0);

    // R3, R5, R7: deep levels
    cur_req = "R3 R5 R7";
    for (int c = 0; c < 4; c++) begin
      rx_code_hi = c[1]; rx_code_lo = c[0]; tx_code = c[1:0];
      both_fill(258);
      chk("deep rx full", rx_count, 256);
      both_drain(258);
    end

    // R8: transmit enable gating and drop on first byte
    cur_req = "R8";
    tx_code = 2'b00;
    tx_en = 0; step();
    chk("tx_irq disabled", tx_irq, 0);
    tx_en = 1; step();
    chk("tx_irq enabled empty", tx_irq, 1);
    tx_push = 1; tx_wdata = 8'h77; step();
    chk("tx_irq after load", tx_irq, 0);
    tx_pop = 1; step();

    // R10, R11: receive watchdog at depth 8
    cur_req = "R12";
    size_sel = 0; step();
    cur_req = "R11";
    rx_code_hi = 1; rx_code_lo = 1;
    wdog_en = 1; bit_tick = 1;
    idle(80);
    chk("no wdog while empty", rx_irq, 0);
    rxw(1); idle(40); rxw(1);
    idle(62);
    chk("wdog before 64 ticks", rx_irq, 0);
    cur_req = "R10";
    idle(3);
    chk("wdog fired", rx_irq, 1);
    rxw(1);
    chk("wdog kept across push", rx_irq, 1);
    rxr(1);
    chk("wdog cleared by read", rx_irq, 0);
    for (int i = 0; i < 70; i++) begin bit_tick = i[0]; step(); end
    bit_tick = 1;
    idle(70);
    cur_req = "R11";
    wdog_en = 0; step();
    chk("wdog disabled", rx_irq, 0);
    wdog_en = 1; idle(66);
    cur_req = "R12";
    size_sel = 1; step();
    chk("wdog cleared by size change", rx_irq, 0);
    idle(3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule